// File: doc/BRIEF.md
# Multi-Word Command Port Sequencer

This block is the synchronous front end of a table-lookup engine. The host bus is narrower than a command, so a host sends each command as a series of bus words, least significant first, with all key words before the data words. Every word except the last is marked with the LOAD opcode, and the last word carries the real operation. Once the last word arrives, the block presents the assembled key, data and opcode to the engine on a single-slot command interface. If that slot is still occupied, the input is stalled.

The engine answers after a fixed latency and echoes the opcode with each response. The block builds an output sequence that depends on the opcode:
- a search gives the data words,
- a queue read gives the key words followed by the data words,
- every other operation gives only a status word.

In every case the packed status word is added either first or last, as a configuration input selects. The host walks through the words with an advance strobe. There is no backpressure on the output side, so a new response replaces the old one at once, even if the old one was never read. A new command can be loaded while an earlier result is still being unloaded.

Top module: `cmdport_seq`

## Requirements
- R1: A word is taken on a rising edge where `din_valid_i` and `din_ready_o` are both high. Taken words are placed at successive bus-word positions, least significant first, with key words before data words. Opcode LOAD (1) only stores the word. Any other opcode except NOP stores the word at the next position and ends the command. In the cycle after that edge, `cmd_valid_o` is high and `cmd_op_o`, `cmd_key_o` and `cmd_data_o` hold the assembled command.
- R2: Bits of the last key word that lie above the key width are dropped. With a 48-bit key on a 32-bit bus, bits 31:16 of the second word never reach `cmd_key_o`.
- R3: A word tagged NOP (0) is taken but does not advance the position and does not issue a command.
- R4: While `cmd_valid_o` is high and `cmd_ready_i` is low, `din_ready_o` is low and the command outputs hold steady. The word the host keeps holding is taken on the first edge after `cmd_ready_i` rises.
- R5: The status word is assembled from the response as follows: bits 25:0 carry the index, and bits 26 to 31 carry `rsp_flags_i[0]` to `rsp_flags_i[5]` in that order (sync write exception, processor write exception, learned queue, aged queue, match, full).
- R6: The output sequence depends on the response opcode:
  - SEARCH (2) gives the data words.
  - The queue reads, learned (6) and aged (7), give the key words, zero-padded, and then the data words.
  - Any other opcode gives no key or data words.
  - The status word comes first when `cfg_stat_first_i` is high and last otherwise.
- R7: `dout_valid_o` goes high for exactly one cycle per result. In normal mode it is high in the same cycle the first word appears. With `cfg_early_valid_i` high it is high one cycle earlier.
- R8: A high `dout_adv_i` at a rising edge puts the next word on `dout_o` after that edge. An advance at the last word has no effect.
- R9: A new response overwrites the current result and restarts it at its first word, whether or not the current result was unloaded.
- R10: With an engine that answers one cycle after taking a command, the first result word appears three clocks after the final input word. A following command can be loaded during that time.
- R11: After reset, `din_ready_o` is high, and `cmd_valid_o`, `dout_valid_o` and `dout_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_early_valid_i | input | 1 | Assert output-valid one cycle before the first word |
| cfg_stat_first_i | input | 1 | Put the status word before the key/data words |
| din_i | input | BUS_W | Input data word, right aligned |
| op_i | input | 4 | Opcode of the current input word |
| din_valid_i | input | 1 | Input word strobe |
| din_ready_o | output | 1 | Input word will be taken at this edge |
| cmd_valid_o | output | 1 | Assembled command available to the engine |
| cmd_ready_i | input | 1 | Engine takes the command |
| cmd_op_o | output | 4 | Command opcode |
| cmd_key_o | output | KEY_W | Assembled key |
| cmd_data_o | output | DATA_W | Assembled data |
| rsp_valid_i | input | 1 | Engine response present |
| rsp_op_i | input | 4 | Opcode echoed with the response |
| rsp_key_i | input | KEY_W | Response key |
| rsp_data_i | input | DATA_W | Response data |
| rsp_index_i | input | 26 | Response entry index |
| rsp_flags_i | input | 6 | Response flags, status bits 26 to 31 |
| dout_adv_i | input | 1 | Advance to the next result word |
| dout_valid_o | output | 1 | New-result pulse |
| dout_o | output | BUS_W | Current result word |

## Verification
The bench builds the block with a 32-bit bus, a 48-bit key and a 32-bit data field. With these values the key spans two input words, and half of the second word must be dropped. They also give the longest output sequence, four words for a queue read, with zero padding in the upper half of the second key word. The one-word status placement can be tested at both ends. The bench's engine model answers one cycle after taking a command. This puts the three-clock search latency, the overlap of loading with unloading, and the overwrite of an unread result within reach of fixed-cycle checks.

// File: rtl/cmdport_pkg.sv
`timescale 1ns/1ps
package cmdport_pkg;
  localparam int STAT_W = 32;
  localparam int IDX_W  = 26;
  localparam int FLAG_W = 6;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LOAD   = 4'd1,
    OP_SEARCH = 4'd2,
    OP_LEARN  = 4'd3,
    OP_INSERT = 4'd4,
    OP_DELETE = 4'd5,
    OP_RD_LQ  = 4'd6,
    OP_RD_AQ  = 4'd7
  } op_e;

  function automatic int beats(input int width, input int bus);
    return (width + bus - 1) / bus;
  endfunction
endpackage

// File: rtl/cmdport_load.sv
`timescale 1ns/1ps
module cmdport_load
  import cmdport_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int KEY_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  din_i,
  input  logic [3:0]        op_i,
  input  logic              din_valid_i,
  output logic              din_ready_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [3:0]        cmd_op_o,
  output logic [KEY_W-1:0]  cmd_key_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  localparam int KEY_BEATS = beats(KEY_W, BUS_W);
  localparam int IN_BEATS  = KEY_BEATS + beats(DATA_W, BUS_W);
  localparam int ASM_W     = IN_BEATS * BUS_W;
  localparam int PTR_W     = $clog2(IN_BEATS + 1);

  logic [ASM_W-1:0]  asm_q, asm_w;
  logic [PTR_W-1:0]  pos_q;
  logic              take, is_nop, is_load, room;
  logic              cmd_valid_q;
  logic [3:0]        cmd_op_q;
  logic [KEY_W-1:0]  cmd_key_q;
  logic [DATA_W-1:0] cmd_data_q;

  assign din_ready_o = !cmd_valid_q || cmd_ready_i;
  assign take        = din_valid_i && din_ready_o;
  assign is_nop      = (op_i == OP_NOP);
  assign is_load     = (op_i == OP_LOAD);
  assign room        = (pos_q < PTR_W'(IN_BEATS));

  // Assembly image including the word taken at this edge
  always_comb begin
    asm_w = asm_q;
    if (take && !is_nop && room)
      asm_w[int'(pos_q)*BUS_W +: BUS_W] = din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q       <= '0;
      pos_q       <= '0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= '0;
      cmd_key_q   <= '0;
      cmd_data_q  <= '0;
    end else begin
      if (cmd_ready_i) cmd_valid_q <= 1'b0;
      if (take && !is_nop) begin
        if (is_load) begin
          asm_q <= asm_w;
          if (room) pos_q <= pos_q + 1'b1;
        end else begin
          cmd_valid_q <= 1'b1;
          cmd_op_q    <= op_i;
          cmd_key_q   <= asm_w[KEY_W-1:0];
          cmd_data_q  <= asm_w[KEY_BEATS*BUS_W +: DATA_W];
          asm_q       <= '0;
          pos_q       <= '0;
        end
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = cmd_op_q;
  assign cmd_key_o   = cmd_key_q;
  assign cmd_data_o  = cmd_data_q;
endmodule

// File: rtl/cmdport_pack.sv
`timescale 1ns/1ps
module cmdport_pack
  import cmdport_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int KEY_W   = 48,
  parameter int DATA_W  = 32,
  parameter int OUT_MAX = 4,
  parameter int CNT_W   = 3
) (
  input  logic                            stat_first_i,
  input  logic [3:0]                      op_i,
  input  logic [KEY_W-1:0]                key_i,
  input  logic [DATA_W-1:0]               data_i,
  input  logic [IDX_W-1:0]                index_i,
  input  logic [FLAG_W-1:0]               flags_i,
  output logic [OUT_MAX-1:0][BUS_W-1:0]   words_o,
  output logic [CNT_W-1:0]                cnt_o
);
  localparam int KEY_BEATS  = beats(KEY_W, BUS_W);
  localparam int DATA_BEATS = beats(DATA_W, BUS_W);
  localparam int STAT_BEATS = beats(STAT_W, BUS_W);

  logic [KEY_BEATS*BUS_W-1:0]  key_pad;
  logic [DATA_BEATS*BUS_W-1:0] data_pad;
  logic [STAT_BEATS*BUS_W-1:0] stat_pad;
  logic                        has_key, has_data;

  assign key_pad  = (KEY_BEATS*BUS_W)'(key_i);
  assign data_pad = (DATA_BEATS*BUS_W)'(data_i);
  assign stat_pad = (STAT_BEATS*BUS_W)'({flags_i, index_i});
  assign has_key  = (op_i == OP_RD_LQ) || (op_i == OP_RD_AQ);
  assign has_data = has_key || (op_i == OP_SEARCH);

  always_comb begin
    int n;
    n       = 0;
    words_o = '0;
    if (stat_first_i)
      for (int s = 0; s < STAT_BEATS; s++) begin
        words_o[n] = stat_pad[s*BUS_W +: BUS_W];
        n++;
      end
    if (has_key)
      for (int k = 0; k < KEY_BEATS; k++) begin
        words_o[n] = key_pad[k*BUS_W +: BUS_W];
        n++;
      end
    if (has_data)
      for (int d = 0; d < DATA_BEATS; d++) begin
        words_o[n] = data_pad[d*BUS_W +: BUS_W];
        n++;
      end
    if (!stat_first_i)
      for (int s = 0; s < STAT_BEATS; s++) begin
        words_o[n] = stat_pad[s*BUS_W +: BUS_W];
        n++;
      end
    cnt_o = CNT_W'(n);
  end
endmodule

// File: rtl/cmdport_unload.sv
`timescale 1ns/1ps
module cmdport_unload #(
  parameter int BUS_W   = 32,
  parameter int OUT_MAX = 4,
  parameter int PTR_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cap_i,
  input  logic [OUT_MAX-1:0][BUS_W-1:0] words_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic                          adv_i,
  input  logic                          early_i,
  output logic [BUS_W-1:0]              dout_o,
  output logic                          dout_valid_o,
  output logic [PTR_W-1:0]              ptr_o,
  output logic [CNT_W-1:0]              cnt_o
);
  logic [OUT_MAX-1:0][BUS_W-1:0] buf_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [PTR_W-1:0]              ptr_q;
  logic                          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cap_i;
      if (cap_i) begin
        buf_q <= words_i;
        cnt_q <= cnt_i;
        ptr_q <= '0;
      end else if (adv_i && (CNT_W'(ptr_q) + 1'b1 < cnt_q)) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign dout_o       = buf_q[ptr_q];
  // Early mode flags the response in the cycle it is captured
  assign dout_valid_o = early_i ? cap_i : vld_q;
  assign ptr_o        = ptr_q;
  assign cnt_o        = cnt_q;
endmodule

// File: rtl/cmdport_seq.sv
`timescale 1ns/1ps
module cmdport_seq
  import cmdport_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int KEY_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_early_valid_i,
  input  logic              cfg_stat_first_i,
  input  logic [BUS_W-1:0]  din_i,
  input  logic [3:0]        op_i,
  input  logic              din_valid_i,
  output logic              din_ready_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [3:0]        cmd_op_o,
  output logic [KEY_W-1:0]  cmd_key_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic [3:0]        rsp_op_i,
  input  logic [KEY_W-1:0]  rsp_key_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [25:0]       rsp_index_i,
  input  logic [5:0]        rsp_flags_i,
  input  logic              dout_adv_i,
  output logic              dout_valid_o,
  output logic [BUS_W-1:0]  dout_o
);
  localparam int OUT_MAX   = beats(KEY_W, BUS_W) + beats(DATA_W, BUS_W) + beats(STAT_W, BUS_W);
  localparam int OUT_PTR_W = $clog2(OUT_MAX);
  localparam int OUT_CNT_W = $clog2(OUT_MAX + 1);

  logic [OUT_MAX-1:0][BUS_W-1:0] res_words;
  logic [OUT_CNT_W-1:0]          res_cnt;
  logic [OUT_PTR_W-1:0]          out_ptr;
  logic [OUT_CNT_W-1:0]          out_cnt;

  cmdport_load #(.BUS_W(BUS_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_load (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .din_i       (din_i),
    .op_i        (op_i),
    .din_valid_i (din_valid_i),
    .din_ready_o (din_ready_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_op_o    (cmd_op_o),
    .cmd_key_o   (cmd_key_o),
    .cmd_data_o  (cmd_data_o)
  );

  cmdport_pack #(
    .BUS_W(BUS_W), .KEY_W(KEY_W), .DATA_W(DATA_W), .OUT_MAX(OUT_MAX), .CNT_W(OUT_CNT_W)
  ) u_pack (
    .stat_first_i (cfg_stat_first_i),
    .op_i         (rsp_op_i),
    .key_i        (rsp_key_i),
    .data_i       (rsp_data_i),
    .index_i      (rsp_index_i),
    .flags_i      (rsp_flags_i),
    .words_o      (res_words),
    .cnt_o        (res_cnt)
  );

  cmdport_unload #(
    .BUS_W(BUS_W), .OUT_MAX(OUT_MAX), .PTR_W(OUT_PTR_W), .CNT_W(OUT_CNT_W)
  ) u_unload (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_i        (rsp_valid_i),
    .words_i      (res_words),
    .cnt_i        (res_cnt),
    .adv_i        (dout_adv_i),
    .early_i      (cfg_early_valid_i),
    .dout_o       (dout_o),
    .dout_valid_o (dout_valid_o),
    .ptr_o        (out_ptr),
    .cnt_o        (out_cnt)
  );
endmodule

// File: rtl/cmdport_seq_chk.sv
`timescale 1ns/1ps
module cmdport_seq_chk #(
  parameter int KEY_W = 48,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_early_valid_i,
  input logic             din_valid_i,
  input logic             din_ready_o,
  input logic [3:0]       op_i,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic [3:0]       cmd_op_o,
  input logic [KEY_W-1:0] cmd_key_o,
  input logic             rsp_valid_i,
  input logic             dout_valid_o,
  input logic             dout_adv_i,
  input logic [PTR_W-1:0] out_ptr,
  input logic [CNT_W-1:0] out_cnt
);
  a_r1_final_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_valid_i && din_ready_o && op_i != 4'd0 && op_i != 4'd1) |=> cmd_valid_o);

  a_r3_nop_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_valid_i && din_ready_o && op_i == 4'd0) |=> !cmd_valid_o);

  a_r4_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_key_o)));

  a_r7_late_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_early_valid_i && rsp_valid_i) |=> (dout_valid_o || cfg_early_valid_i));

  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_adv_i && !rsp_valid_i && (CNT_W'(out_ptr) + 1'b1 < out_cnt))
      |=> (out_ptr == $past(out_ptr) + 1'b1));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dout_adv_i && !rsp_valid_i) |=> $stable(out_ptr));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> (out_ptr == '0));
endmodule

bind cmdport_seq cmdport_seq_chk #(
  .KEY_W(KEY_W), .PTR_W(OUT_PTR_W), .CNT_W(OUT_CNT_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cfg_early_valid_i (cfg_early_valid_i),
  .din_valid_i       (din_valid_i),
  .din_ready_o       (din_ready_o),
  .op_i              (op_i),
  .cmd_valid_o       (cmd_valid_o),
  .cmd_ready_i       (cmd_ready_i),
  .cmd_op_o          (cmd_op_o),
  .cmd_key_o         (cmd_key_o),
  .rsp_valid_i       (rsp_valid_i),
  .dout_valid_o      (dout_valid_o),
  .dout_adv_i        (dout_adv_i),
  .out_ptr           (out_ptr),
  .out_cnt           (out_cnt)
);

// File: tb/cmdport_seq_test.sv
`timescale 1ns/1ps
module cmdport_seq_test;
  import cmdport_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_early = 1'b0, cfg_sf = 1'b0;
  logic [31:0] din = '0;
  logic [3:0]  op_s = '0;
  logic        din_valid = 1'b0, din_ready;
  logic        cmd_valid, cmd_ready = 1'b1;
  logic [3:0]  cmd_op;
  logic [47:0] cmd_key;
  logic [31:0] cmd_data;
  logic        rsp_valid = 1'b0;
  logic [3:0]  rsp_op = '0;
  logic [47:0] rsp_key = '0;
  logic [31:0] rsp_data = '0;
  logic [25:0] rsp_index = '0;
  logic [5:0]  rsp_flags = '0;
  logic        dout_adv = 1'b0, dout_valid;
  logic [31:0] dout;

  int checks = 0, errors = 0;
  logic [31:0] exp_w [4];
  int exp_n;

  always #2.5 clk = ~clk;

  cmdport_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_early_valid_i(cfg_early), .cfg_stat_first_i(cfg_sf),
    .din_i(din), .op_i(op_s), .din_valid_i(din_valid), .din_ready_o(din_ready),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_key_o(cmd_key), .cmd_data_o(cmd_data),
    .rsp_valid_i(rsp_valid), .rsp_op_i(rsp_op), .rsp_key_i(rsp_key), .rsp_data_i(rsp_data),
    .rsp_index_i(rsp_index), .rsp_flags_i(rsp_flags),
    .dout_adv_i(dout_adv), .dout_valid_o(dout_valid), .dout_o(dout)
  );

  // Engine model: answers one cycle after taking a command
  initial forever begin
    @(posedge clk);
    rsp_valid <= cmd_valid && cmd_ready;
    rsp_op    <= cmd_op;
    rsp_key   <= cmd_key;
    rsp_data  <= cmd_data ^ 32'h5A5A_5A5A;
    rsp_index <= cmd_key[25:0] ^ 26'h1;
    rsp_flags <= cmd_key[37:32];
  end

  // {op, key, data, stat_first, early, expected word count}
  localparam logic [88:0] VEC [7] = '{
    {4'd2, 48'h1234_89AB_CDEF, 32'hDEAD_BEEF, 1'b0, 1'b0, 3'd2},
    {4'd6, 48'hA0B1_C2D3_E4F5, 32'h0102_0304, 1'b0, 1'b0, 3'd4},
    {4'd3, 48'h0F0E_0D0C_0B0A, 32'h1111_2222, 1'b1, 1'b1, 3'd1},
    {4'd7, 48'h5555_6666_7777, 32'h8888_9999, 1'b1, 1'b0, 3'd4},
    {4'd2, 48'hFFFF_0000_FFFF, 32'h0000_0001, 1'b1, 1'b1, 3'd2},
    {4'd5, 48'h0003_0000_0040, 32'h0000_0000, 1'b0, 1'b0, 3'd1},
    {4'd4, 48'h003F_03FF_FFFF, 32'hCAFE_F00D, 1'b0, 1'b1, 3'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [31:0] d);
    @(negedge clk);
    din = d; op_s = op; din_valid = 1'b1;
    while (!din_ready) @(negedge clk);
    @(posedge clk);
    #1 din_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [3:0] op, input logic [47:0] key, input logic [31:0] d);
    send(OP_LOAD, key[31:0]);
    send(OP_LOAD, {16'hFFFF, key[47:32]});   // upper half must be dropped (R2)
    send(op, d);
  endtask

  task automatic make_exp(input logic [3:0] op, input logic [47:0] key,
                          input logic [31:0] d, input logic sf);
    logic [31:0] st;
    st = {key[37:32], key[25:0] ^ 26'h1};      // R5 layout
    exp_n = 0;
    if (sf) begin exp_w[exp_n] = st; exp_n++; end
    if (op == 4'd6 || op == 4'd7) begin
      exp_w[exp_n] = key[31:0]; exp_n++;
      exp_w[exp_n] = {16'h0, key[47:32]}; exp_n++;
    end
    if (op == 4'd6 || op == 4'd7 || op == 4'd2) begin
      exp_w[exp_n] = d ^ 32'h5A5A_5A5A; exp_n++;
    end
    if (!sf) begin exp_w[exp_n] = st; exp_n++; end
  endtask

  // Called right after the edge that took the final word
  task automatic check_result(input logic [3:0] op, input logic [47:0] key,
                              input logic [31:0] d, input logic early);
    @(negedge clk);
    chk("R1 cmd_valid", cmd_valid, 1);
    chk("R1 cmd_op", cmd_op, op);
    chk("R2 cmd_key", cmd_key, key);
    chk("R1 cmd_data", cmd_data, d);
    chk("R7 no valid yet", dout_valid, 0);
    @(negedge clk);
    chk("R7 early pulse", dout_valid, early);
    @(negedge clk);
    chk("R7 valid with first word", dout_valid, !early);
    chk("R10 R6 R5 first word", dout, exp_w[0]);
    for (int i = 1; i < exp_n; i++) begin
      dout_adv = 1'b1;
      @(negedge clk);
      dout_adv = 1'b0;
      chk("R8 R6 next word", dout, exp_w[i]);
      chk("R7 single pulse", dout_valid, 0);
    end
    dout_adv = 1'b1;
    @(negedge clk);
    dout_adv = 1'b0;
    chk("R8 advance past last", dout, exp_w[exp_n-1]);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 din_ready", din_ready, 1);
    chk("R11 cmd_valid", cmd_valid, 0);
    chk("R11 dout_valid", dout_valid, 0);
    chk("R11 dout", dout, 0);

    // Table walk: R1 R2 R5 R6 R7 R8 R10
    for (int v = 0; v < 7; v++) begin
      logic [88:0] e;
      e = VEC[v];
      @(negedge clk);
      cfg_sf = e[4]; cfg_early = e[3];
      make_exp(e[88:85], e[84:37], e[36:5], e[4]);
      chk("R6 word count", exp_n, e[2:0]);
      send_cmd(e[88:85], e[84:37], e[36:5]);
      check_result(e[88:85], e[84:37], e[36:5], e[3]);
      repeat (2) @(negedge clk);
    end

    // R3: NOP inside a load sequence changes nothing
    @(negedge clk);
    cfg_sf = 1'b0; cfg_early = 1'b0;
    send(OP_LOAD, 32'h7654_3210);
    send(OP_NOP, 32'hBAD0_BAD0);
    @(negedge clk);
    chk("R3 nop issues nothing", cmd_valid, 0);
    send(OP_LOAD, 32'hFFFF_00A5);
    send(OP_SEARCH, 32'h1357_9BDF);
    make_exp(OP_SEARCH, 48'h00A5_7654_3210, 32'h1357_9BDF, 1'b0);
    check_result(OP_SEARCH, 48'h00A5_7654_3210, 32'h1357_9BDF, 1'b0);
    repeat (2) @(negedge clk);

    // R10 + R9: load B while A unloads; B overwrites A mid-unload
    send_cmd(OP_SEARCH, 48'h0000_1111_2222, 32'h0000_00AA);  // A final at E0
    send_cmd(OP_SEARCH, 48'h0000_3333_4444, 32'h0000_00BB);  // B final at E3
    @(negedge clk);
    chk("R10 A first word during B load", dout, 32'h0000_00AA ^ 32'h5A5A_5A5A);
    chk("R10 B issued", cmd_key, 48'h0000_3333_4444);
    dout_adv = 1'b1;
    @(negedge clk);
    dout_adv = 1'b0;
    chk("R8 A status", dout, {6'h00, 26'h1112222 ^ 26'h1});
    @(negedge clk);
    chk("R9 B restarts at first word", dout, 32'h0000_00BB ^ 32'h5A5A_5A5A);
    chk("R9 B valid", dout_valid, 1);
    repeat (2) @(negedge clk);

    // R4: engine stall holds input and command
    cmd_ready = 1'b0;
    send_cmd(OP_SEARCH, 48'h0000_5555_6666, 32'h0000_00CC);
    @(negedge clk);
    din = 32'h9999_8888; op_s = OP_LOAD; din_valid = 1'b1;
    chk("R4 not ready while stalled", din_ready, 0);
    repeat (2) @(negedge clk);
    chk("R4 still not ready", din_ready, 0);
    chk("R4 cmd held", cmd_valid, 1);
    chk("R4 key held", cmd_key, 48'h0000_5555_6666);
    chk("R4 no response during stall", dout_valid, 0);
    cmd_ready = 1'b1;
    #1;
    chk("R4 ready on release", din_ready, 1);
    @(posedge clk);
    #1 din_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 stalled result", dout, 32'h0000_00CC ^ 32'h5A5A_5A5A);
    send(OP_LOAD, 32'hFFFF_0077);
    send(OP_SEARCH, 32'h0000_00DD);
    make_exp(OP_SEARCH, 48'h0077_9999_8888, 32'h0000_00DD, 1'b0);
    check_result(OP_SEARCH, 48'h0077_9999_8888, 32'h0000_00DD, 1'b0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule